// File: doc/BRIEF.md
# Folded Seven-Tap Linear-Phase FIR Filter

This block is a seven-tap finite impulse response filter with constant fixed-point coefficients. It accepts one signed 16-bit sample per clock, marked by a valid strobe. Each accepted sample moves a register delay line forward by one place. The new sample and the six stored samples are weighted by hard-wired coefficients, summed, scaled back by 2^15 and saturated. The result appears on the output one clock later, together with an output valid.

The coefficient set is symmetric about the centre tap. Taps k and 6-k therefore carry the same weight. The datapath adds each mirrored pair of samples first, so each output needs only four multiplications. A parameter chooses how those products are formed. One option is a radix-4 recoded partial-product multiplier. The other is the plain multiply operator. Both options give bit-identical results.

Top module: `fir_sym_top`

## Requirements
- R1: A synchronous reset that is high at a rising edge clears all six history registers, drives `out_valid` low and sets `out_sample` to 0 at that edge. This holds even if `in_valid` is high in the same cycle.
- R2: `out_valid` is high in the cycle after each edge at which `in_valid` was high, and low in the cycle after each edge at which it was low. This gives exactly one result per accepted sample, with a latency of one clock.
- R3: For an accepted sample x[n], the result is sum over k=0..6 of x[n-k]*c[k]. The weights are c = {+124, -1099, -7464, +20252, -7464, -1099, +124}, with c[0] applied to the newest sample. The sum is arithmetically shifted right by 15 (rounding toward minus infinity) and presented as signed 16-bit two's complement.
- R4: Until six samples have been accepted since reset, any history position not yet filled counts as zero. For example, an impulse of 32767 followed by zeros gives floor(32767*c[k]/32768) for k = 0..6.
- R5: A cycle with `in_valid` low does not advance the delay line. The result of the next accepted sample is the same as if the idle cycles had not occurred.
- R6: While `in_valid` is low, `out_sample` keeps the value it had in the previous cycle.
- R7: A shifted sum above 32767 is output as 32767 (0x7FFF). A shifted sum below -32768 is output as -32768 (0x8000).
- R8: Each of the four pair-times-coefficient products equals the exact signed product of a 17-bit pre-added pair and a 16-bit coefficient. This holds for every input value, including a pair formed from two most-negative samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | DATA_W (16) | Signed input sample, two's complement |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_sample | output | DATA_W (16) | Signed filtered result, saturated |

## Verification
Assertions check the following on every cycle:
- the one-clock relation between the input and output valids;
- the hold of the delay line and of the output register during idle cycles;
- the reset clearing;
- the clamp value whenever the pre-saturation sum is out of range;
- each recoded product against an exact signed product.

The arithmetic itself is checked only by the bench scenarios. These compare outputs against a seven-weight model that does not fold the taps. The scenarios cover:
- the impulse response from an empty history after reset;
- runs interleaved with idle gaps;
- both saturation extremes;
- a reset in the middle of a stream.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

  // Filter geometry
  localparam int NTAPS  = 7;
  localparam int NPAIR  = (NTAPS + 1) / 2;
  localparam int COEF_W = 16;

  // Q15 weight for folded position p (p = 0 outermost pair, NPAIR-1 centre)
  function automatic logic signed [COEF_W-1:0] coef_of(input int p);
    logic signed [COEF_W-1:0] c;
    case (p)
      0:       c = 16'sd124;
      1:       c = -16'sd1099;
      2:       c = -16'sd7464;
      default: c = 16'sd20252;
    endcase
    return c;
  endfunction

  // Radix-4 recoding of one overlapping bit triplet
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  function automatic booth_sel_t booth_enc(input logic [2:0] t);
    booth_sel_t s;
    s = '0;
    case (t)
      3'b001, 3'b010: s.one = 1'b1;
      3'b011:         s.two = 1'b1;
      3'b100:         begin s.two = 1'b1; s.neg = 1'b1; end
      3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
      default:        s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fir_sym_delay.sv
module fir_sym_delay #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  line
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int s = 1; s < DEPTH; s++) begin
        line[s] <= line[s-1];
      end
    end
  end

  // R1: history empties on reset
  assert_line_clear_R1: assert property (@(posedge clk)
    rst |=> (line == '0));

  // R5: idle cycles leave the history untouched
  assert_line_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(line));

  // R5: an accepted sample lands in the first stage
  assert_line_load_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (line[0] == $past(din)));

endmodule

// File: rtl/fir_sym_fold.sv
module fir_sym_fold #(
  parameter int DATA_W = 16,
  parameter int NT     = 7,
  localparam int NP    = (NT + 1) / 2
) (
  input  logic [NT-1:0][DATA_W-1:0] taps,
  output logic [NP-1:0][DATA_W:0]   pairs
);

  for (genvar p = 0; p < NP; p++) begin : g_pair
    if (p == NT - 1 - p) begin : g_centre
      assign pairs[p] = {taps[p][DATA_W-1], taps[p]};
    end else begin : g_sum
      assign pairs[p] = {taps[p][DATA_W-1], taps[p]}
                      + {taps[NT-1-p][DATA_W-1], taps[NT-1-p]};
    end
  end

endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import fir_sym_pkg::*;
#(
  parameter int A_W = 17,
  parameter int B_W = 16,
  localparam int PW   = A_W + B_W,
  localparam int NDIG = B_W / 2
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [PW-1:0]  p
);

  logic [PW-1:0]            a_ext;
  logic [B_W:0]             bxe;
  logic [NDIG-1:0][PW-1:0]  pps;

  assign a_ext = {{B_W{a[A_W-1]}}, a};
  assign bxe   = {b, 1'b0};

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    booth_sel_t     sel;
    logic [PW-1:0]  mag;
    logic [PW-1:0]  sgn;
    assign sel     = booth_enc(bxe[2*g+2 -: 3]);
    assign mag     = sel.two ? (a_ext << 1) : (sel.one ? a_ext : '0);
    assign sgn     = sel.neg ? (~mag + 1'b1) : mag;
    assign pps[g]  = sgn << (2*g);
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < NDIG; i++) begin
      p = p + pps[i];
    end
  end

endmodule

// File: rtl/fir_sym_sat.sv
module fir_sym_sat #(
  parameter int IN_W  = 35,
  parameter int SHIFT = 15,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clip_hi,
  output logic             clip_lo
);

  logic signed [IN_W-1:0] sh;
  logic                   fits;

  assign sh      = $signed(din) >>> SHIFT;
  assign fits    = (&sh[IN_W-1:OUT_W-1]) | ~(|sh[IN_W-1:OUT_W-1]);
  assign clip_hi = ~fits & ~sh[IN_W-1];
  assign clip_lo = ~fits &  sh[IN_W-1];

  always_comb begin
    if (clip_hi)      dout = {1'b0, {(OUT_W-1){1'b1}}};
    else if (clip_lo) dout = {1'b1, {(OUT_W-1){1'b0}}};
    else              dout = sh[OUT_W-1:0];
  end

endmodule

// File: rtl/fir_sym_top.sv
module fir_sym_top
  import fir_sym_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAC_W    = 15,
  parameter bit USE_BOOTH = 1'b1,
  localparam int PAIR_W = DATA_W + 1,
  localparam int PROD_W = PAIR_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(NPAIR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);

  logic [NTAPS-2:0][DATA_W-1:0] line;
  logic [NTAPS-1:0][DATA_W-1:0] xv;
  logic [NPAIR-1:0][PAIR_W-1:0] pairs;
  logic [NPAIR-1:0][PROD_W-1:0] prods;
  logic [ACC_W-1:0]             acc;
  logic [DATA_W-1:0]            sat_val;
  logic                         sat_hi;
  logic                         sat_lo;

  fir_sym_delay #(.DATA_W(DATA_W), .DEPTH(NTAPS-1)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .din      (in_sample),
    .line     (line)
  );

  assign xv[0]         = in_sample;
  assign xv[NTAPS-1:1] = line;

  fir_sym_fold #(.DATA_W(DATA_W), .NT(NTAPS)) u_fold (
    .taps  (xv),
    .pairs (pairs)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_mul
    localparam logic signed [COEF_W-1:0] CW = coef_of(p);
    logic signed [PROD_W-1:0] ps;
    logic signed [PROD_W-1:0] cs;
    assign ps = $signed(pairs[p]);
    assign cs = CW;
    if (USE_BOOTH) begin : g_booth
      booth_r4_mul #(.A_W(PAIR_W), .B_W(COEF_W)) u_mul (
        .a (pairs[p]),
        .b (CW),
        .p (prods[p])
      );
      // R8: recoded product matches the exact signed product
      assert_booth_exact_R8: assert property (@(posedge clk) disable iff (rst)
        $signed(prods[p]) == ps * cs);
    end else begin : g_plain
      assign prods[p] = ps * cs;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPAIR; i++) begin
      acc = acc + {{(ACC_W-PROD_W){prods[i][PROD_W-1]}}, prods[i]};
    end
  end

  fir_sym_sat #(.IN_W(ACC_W), .SHIFT(FRAC_W), .OUT_W(DATA_W)) u_sat (
    .din     (acc),
    .dout    (sat_val),
    .clip_hi (sat_hi),
    .clip_lo (sat_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= sat_val;
    end
  end

  // R1: reset clears the output register
  assert_out_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0));

  // R2: one result per accepted sample, one clock later
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: idle cycles keep the last result
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample));

  // R7: out-of-range sums clamp to the rails
  assert_clip_high_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_hi) |=> (out_sample == {1'b0, {(DATA_W-1){1'b1}}}));
  assert_clip_low_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_lo) |=> (out_sample == {1'b1, {(DATA_W-1){1'b0}}}));
  assert_clip_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(sat_hi && sat_lo));

endmodule

// File: tb/fir_sym_top_tb.sv
module fir_sym_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic [15:0] out_sample;

  int vectors = 0;
  int fails   = 0;

  longint hist [7];
  logic [15:0] last_out;

  always #4 clk = ~clk;

  fir_sym_top u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  function automatic longint gold_coef(input int k);
    int m;
    m = (k > 3) ? 6 - k : k;
    case (m)
      0: return 124;
      1: return -1099;
      2: return -7464;
      default: return 20252;
    endcase
  endfunction

  function automatic logic [15:0] gold_out();
    longint s;
    s = 0;
    for (int k = 0; k < 7; k++) s += hist[k] * gold_coef(k);
    s = s >>> 15;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 7; k++) hist[k] = 0;
    last_out = '0;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h) at %0t",
               tag, $signed(act), act, $signed(exp), exp, $time);
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] x, input string tag);
    logic [15:0] exp;
    in_valid  = v;
    in_sample = x;
    if (v) begin
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(x));
      exp = gold_out();
      last_out = exp;
    end else begin
      exp = last_out;
    end
    @(posedge clk);
    #2;
    check({tag, " valid"}, {15'd0, out_valid}, {15'd0, v});
    check({tag, " data"}, out_sample, exp);
  endtask

  task automatic pulse_reset(input logic v, input logic [15:0] x);
    rst = 1'b1;
    in_valid = v;
    in_sample = x;
    @(posedge clk);
    #2;
    check("R1 reset valid", {15'd0, out_valid}, 16'd0);
    check("R1 reset data", out_sample, 16'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    model_clear();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    model_clear();
    repeat (2) @(posedge clk);
    #2;
    // R1: state straight after power-up reset
    check("R1 initial valid", {15'd0, out_valid}, 16'd0);
    check("R1 initial data", out_sample, 16'd0);
    rst = 1'b0;

    // R4: impulse from empty history, R2 timing on each
    apply(1'b1, 16'h7FFF, "R4 R2 impulse");
    for (int i = 0; i < 7; i++) apply(1'b1, 16'h0000, "R4 R3 impulse tail");

    // R5 R6: same samples with idle gaps between them
    apply(1'b1, 16'd1000, "R5 lead");
    apply(1'b0, 16'hDEAD, "R6 idle");
    apply(1'b0, 16'hBEEF, "R6 idle");
    apply(1'b1, 16'hF000, "R5 after gap");
    apply(1'b0, 16'h1234, "R6 idle");
    apply(1'b1, 16'd3000, "R5 after gap");

    // R7: positive clamp pattern (taps 0,3,6 max, others min)
    for (int r = 0; r < 7; r++) begin
      apply(1'b1, (r % 3 == 0) ? 16'h7FFF : 16'h8000, "R7 high clamp");
    end
    apply(1'b0, 16'h0000, "R6 hold after clamp");
    // R7: negative clamp pattern
    for (int r = 0; r < 7; r++) begin
      apply(1'b1, (r % 3 == 0) ? 16'h8000 : 16'h7FFF, "R7 low clamp");
    end
    // R8: two most-negative samples in every pair
    for (int r = 0; r < 7; r++) apply(1'b1, 16'h8000, "R8 R3 min pairs");

    // R1: reset mid-stream dominates a valid input, then R4 empty history
    pulse_reset(1'b1, 16'h4321);
    apply(1'b1, 16'h8000, "R4 after reset");
    apply(1'b1, 16'h0005, "R4 after reset");

    // R3 R8 R2 R5 R6: random stream with random gaps
    for (int i = 0; i < 3000; i++) begin
      logic        v;
      logic [15:0] x;
      v = ($urandom % 10) < 7;
      x = 16'($urandom);
      if (($urandom % 16) == 0) x = ($urandom % 2) ? 16'h7FFF : 16'h8000;
      apply(v, x, "R3 R8 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule